// File: doc/BRIEF.md
# Addressable Latch Bank with Demultiplex Mode

This block keeps eight single-bit values and lets one serial data line update any one of them, chosen by a three-bit index. Two active-low controls, a write enable and a clear, pick one of four modes. In addressed write the chosen bit tracks the data line and the rest keep their values. In hold every bit keeps its value whatever the data and index do. In demultiplex the chosen output shows the data line and all other outputs read low. In clear every output reads low.

Storage is built from clocked cells. While the enable is low, each rising clock edge captures the data line into the indexed cell. The output path shows the data line on the indexed output at once, so that output follows it as a transparent latch would. The value kept when the enable rises is the one captured at the last clock edge with the enable low. Clear empties the cells asynchronously, with no clock edge needed. The controls are plain level pins with no handshake, because nothing here has back-pressure. Several banks can be cascaded by decoding upper index bits outside the block to drive each bank's enable.

Top module: `addressable_latch`

## Requirements
- R1: The index `sel` is a binary number in which `sel[0]` is the least significant bit. Value k picks output `q[k]` and no other output.
- R2: When `clr_n`=1 and `en_n`=0, `q[sel]` equals `din` within the same cycle, and every other output keeps its stored value.
- R3: When `clr_n`=1 and `en_n`=1, all of `q` holds its value while `din` and `sel` change.
- R4: When `clr_n`=0 and `en_n`=0, `q` equals `din` shifted left by `sel`, so every unselected output is 0.
- R5: When `clr_n`=0 and `en_n`=1, `q` is all zero for every value of `din` and `sel`.
- R6: Clear empties the stored bits asynchronously. The outputs read zero before the next rising clock edge after `clr_n` falls.
- R7: When `en_n` rises with `clr_n`=1, the chosen bit keeps the `din` value captured at the last rising clock edge at which `en_n` was 0.
- R8: If `en_n` rises while `clr_n` is 0, every bit ends at zero, the last chosen bit included. The bits stay zero after `clr_n` returns high until the next write.
- R9: While `rst_n` is 0 and after it is released, all stored bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the storage cells |
| rst_n | input | 1 | Asynchronous active-low reset of the storage |
| clr_n | input | 1 | Active-low clear control (mode select) |
| en_n | input | 1 | Active-low write enable (mode select) |
| sel | input | SEL_W | Index of the chosen bit, bit 0 least significant |
| din | input | 1 | Serial data bit |
| q | output | 2**SEL_W | Parallel outputs |

## Verification
The transparent path to the chosen output and the asynchronous clear of the cells can act in the same cycle. This happens when `clr_n` falls while `en_n` is low. The bench provokes it by driving that change between clock edges, after the cells hold a known pattern, and checks the outputs before the next rising edge: only the indexed output may still show `din`. It then raises `en_n` with clear still held and expects all zeros, which tells a correct design apart from one that captures the last write.

// File: rtl/addressable_latch_pkg.sv
package addressable_latch_pkg;

  // Mode encoding is {clr_n, en_n}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } latch_mode_e;

  function automatic latch_mode_e mode_of(input logic clr_n, input logic en_n);
    return latch_mode_e'({clr_n, en_n});
  endfunction

endpackage

// File: rtl/addressable_latch_decode.sv
module addressable_latch_decode #(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [NBITS-1:0] hit
);
  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/addressable_latch_cell.sv
module addressable_latch_cell (
  input  logic clk,
  input  logic arst_n,
  input  logic wr,
  input  logic din,
  output logic bit_q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  bit_q <= 1'b0;
    else if (wr)  bit_q <= din;
  end
endmodule

// File: rtl/addressable_latch_drive.sv
module addressable_latch_drive #(
  parameter int NBITS = 8
) (
  input  logic             pass,
  input  logic [NBITS-1:0] hit,
  input  logic [NBITS-1:0] store,
  input  logic             din,
  output logic [NBITS-1:0] q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_out
    // stored bits are already zero while clear holds the cells
    assign q[i] = (pass && hit[i]) ? din : store[i];
  end
endmodule

// File: rtl/addressable_latch.sv
module addressable_latch
  import addressable_latch_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             en_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic [NBITS-1:0] q
);
  latch_mode_e      mode;
  logic [NBITS-1:0] hit;
  logic [NBITS-1:0] store;
  logic             cell_rst_n;
  logic             wr_any;
  logic             pass;

  assign mode       = mode_of(clr_n, en_n);
  assign cell_rst_n = rst_n & clr_n;
  assign wr_any     = (mode == MODE_WRITE);
  assign pass       = (mode == MODE_WRITE) || (mode == MODE_DEMUX);

  addressable_latch_decode #(.SEL_W(SEL_W)) u_dec (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    addressable_latch_cell u_cell (
      .clk    (clk),
      .arst_n (cell_rst_n),
      .wr     (wr_any & hit[i]),
      .din    (din),
      .bit_q  (store[i])
    );
  end

  addressable_latch_drive #(.NBITS(NBITS)) u_drv (
    .pass  (pass),
    .hit   (hit),
    .store (store),
    .din   (din),
    .q     (q)
  );
endmodule

// File: rtl/addressable_latch_checker.sv
module addressable_latch_checker #(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             en_n,
  input logic [SEL_W-1:0] sel,
  input logic             din,
  input logic [NBITS-1:0] q
);
  a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !en_n) |-> (q[sel] == din));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && en_n && $past(clr_n && en_n)) |-> $stable(q));

  a_r4_demux: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !en_n) |-> (q == (NBITS'(din) << sel)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && en_n) |-> (q == '0));

  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && en_n && $past(clr_n && !en_n)) |-> (q[$past(sel)] == $past(din)));

  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && en_n && $past(!clr_n && en_n)) |-> (q == '0));
endmodule

bind addressable_latch addressable_latch_checker #(.SEL_W(SEL_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .clr_n (clr_n),
  .en_n  (en_n),
  .sel   (sel),
  .din   (din),
  .q     (q)
);

// File: tb/addressable_latch_test.sv
module addressable_latch_test;
  localparam int SEL_W = 3;
  localparam int NBITS = 1 << SEL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr_n = 1'b1;
  logic             en_n = 1'b1;
  logic [SEL_W-1:0] sel = '0;
  logic             din = 1'b0;
  logic [NBITS-1:0] q;

  int checks = 0;
  int fails = 0;
  logic [NBITS-1:0] model = '0;
  logic [NBITS-1:0] exp_q[$];
  string            req_q[$];

  always #2 clk = ~clk;  // 250 MHz

  addressable_latch #(.SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
    .sel(sel), .din(din), .q(q)
  );

  // monitor: compare 1 ns after the driving negedge, before the next posedge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [NBITS-1:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (q !== e) begin
        fails++;
        $display("FAIL %s: q=%b expected %b", r, q, e);
      end
    end
  end

  task automatic apply(input logic c, input logic e, input int s, input logic d, input string r);
    logic [NBITS-1:0] x;
    @(negedge clk);
    clr_n = c; en_n = e; sel = SEL_W'(s); din = d;
    x = c ? model : '0;
    if (!e) x[s] = d;
    exp_q.push_back(x);
    req_q.push_back(r);
    if (!c) model = '0;
    else if (!e) model[s] = d;
  endtask

  initial begin
    #5000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NBITS-1:0] pat;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (q !== '0) begin fails++; $display("FAIL R9: q=%b expected %b", q, 8'h00); end
    rst_n = 1'b1;
    apply(1, 1, 0, 0, "R9");

    // R1/R2/R7: write pattern, one address at a time
    pat = 8'hA5;
    for (int s = 0; s < NBITS; s++) begin
      apply(1, 0, s, pat[s], "R2");
      apply(1, 1, s, pat[s], "R7");
    end
    // R1: single one walks through addresses
    for (int s = 0; s < NBITS; s++) begin
      apply(1, 0, s, 1, "R1");
      apply(1, 0, s, 0, "R1");
    end
    for (int s = 0; s < NBITS; s++) apply(1, 0, s, pat[s], "R2");
    apply(1, 1, 0, 0, "R7");

    // R3: change index and data with enable high
    for (int s = 0; s < NBITS; s++) begin
      apply(1, 1, s, 1, "R3");
      apply(1, 1, NBITS - 1 - s, 0, "R3");
    end

    // R6: clear with enable high falls between edges
    apply(0, 1, 3, 1, "R6");
    apply(1, 1, 3, 1, "R9");

    // restore pattern, then clear while write is open (R6 with R4)
    for (int s = 0; s < NBITS; s++) apply(1, 0, s, ~pat[s], "R2");
    apply(0, 0, 2, 1, "R6");
    apply(0, 1, 2, 1, "R8");
    apply(1, 1, 2, 1, "R8");

    // R4: demultiplex every address, both data values
    for (int s = 0; s < NBITS; s++) begin
      apply(0, 0, s, 1, "R4");
      apply(0, 0, s, 0, "R4");
    end
    apply(0, 0, 5, 1, "R4");
    apply(0, 1, 5, 1, "R8");

    // R5: clear mode ignores index and data
    for (int s = 0; s < NBITS; s++) apply(0, 1, s, s[0], "R5");

    // sweep of all mode, index and data combinations
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < NBITS; s++)
        for (int d = 0; d < 2; d++)
          apply(m[1], m[0], s, d[0], "R1");
    apply(1, 1, 0, 0, "R3");

    repeat (2) @(negedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule